// File: doc/BRIEF.md
# DRAM initialization command sequencer

This block powers up an external DDR2 or DDR3 memory after reset. Once told to start, it issues a fixed, timed series of memory command opcodes. It waits the required interval after each command, and it walks through the configured ranks one at a time. The mode-register payloads are not built here. Each command is an opaque 8-bit opcode handed to a downstream command engine over a valid/ready handshake. A rank select and an ODT-off flag travel with each opcode.

The configuration is captured on the start pulse. It consists of a memory-type code, a handoff flag, the rank count, the memory clock in MHz and the clock rate ratio. Waits are stated in nanoseconds and converted to clock cycles at run time, so the same sequence serves any clock setting. The handoff flag shortens the DDR2 per-rank sequence and selects the user mode-register write in place of the DLL-reset write. An unknown type code stops the block in an error state.

Top module: `dram_init_seq`

## Requirements
- R1: On start, a `mem_type` of 1 selects the DDR2 path and 2 selects the DDR3 path. Any other value moves the block, in the cycle after start, into an error state. In that state `err` is high, `busy` is low, no command is ever presented and start pulses are ignored, until reset.
- R2: A wait of N ns lasts (N × `clk_mhz` × `rate_ratio`) / 1000 cycles, with integer division, plus any fixed cycle count for that step. After a command is accepted (`cmd_valid` and `cmd_ready` both high in a cycle), `cmd_valid` stays low for exactly the step's wait in cycles. A zero wait gives back-to-back commands.
- R3: The DDR2 path starts with one NOP (opcode 0x01) with `rank_sel` all ones and `odt_off` low, followed by a 400 ns wait.
- R4: The DDR3 path starts with one reset/clock-enable command (opcode 0x0C) with `rank_sel` all ones and `odt_off` low. It is followed by a wait of RESET_NS nanoseconds (default 500000) plus 250 cycles.
- R5: Each DDR2 rank's commands carry `rank_sel` one-hot on that rank and `odt_off` high. They begin, with no waits, with precharge-all 0x02, EMR2 0x04, EMR3 0x05 and EMR 0x03.
- R6: In DDR2 handoff mode the only command after that EMR is the user mode-register write 0x06, with no wait.
- R7: In DDR2 non-handoff mode the EMR is followed by these commands, in order: DLL-reset mode register 0x07, precharge-all 0x02, refresh 0x08 with a 200 ns wait, refresh 0x08 with a 200 ns wait, calibration mode register 0x09, EMR with OCD enable 0x0B, and EMR 0x03 with a 200-cycle wait. Only the waits named here are non-zero.
- R8: Each DDR3 rank issues MR2 0x12, MR3 0x13 and MR1 0x11, then MR0 as user value 0x14 in handoff mode or as DLL reset 0x15 otherwise. These commands have no waits, `odt_off` low and `rank_sel` one-hot.
- R9: Ranks are visited in order from 0 to `num_ranks`−1. A count of 0 skips the per-rank phase, and a count above MAX_RANKS (default 4) acts as MAX_RANKS.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `rank_sel` hold their values into the next cycle.
- R11: `busy` is high from the cycle after an accepted start until the last wait has ended. `done` then pulses high for exactly one cycle, with `busy` low. A start pulse while busy has no effect on the sequence.
- R12: A synchronous active-low reset returns the block to idle with all outputs low, including `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin the bring-up when idle |
| handoff | input | 1 | Select the shortened handoff sequence |
| mem_type | input | MTYPE_W (3) | Memory type code: 1 DDR2, 2 DDR3 |
| num_ranks | input | $clog2(MAX_RANKS+1) (3) | Number of ranks to initialize |
| clk_mhz | input | MHZ_W (12) | Memory clock frequency in MHz |
| rate_ratio | input | RATIO_W (3) | Controller-to-memory clock rate ratio |
| cmd_ready | input | 1 | Command engine accepts the opcode |
| cmd_valid | output | 1 | An opcode is presented |
| cmd_op | output | 8 | Command opcode |
| rank_sel | output | MAX_RANKS (4) | Chip-select mask for the opcode |
| odt_off | output | 1 | Termination forced off for this command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |
| err | output | 1 | Unsupported memory type; block halted |

## Verification
A step pointer that slips shows up at the next accepted command, as a wrong opcode or a missing one. A rank counter that slips shows up as a wrong `rank_sel` one-hot, or as the wrong number of rank passes before `done`. A wrong delay load, or a timer that ends early or late, shows up as an idle gap of the wrong length right after the command that owns the wait. A wrong end-of-sequence flag shows up as `done` arriving at the wrong time, or `busy` dropping at the wrong time. Every error becomes visible within one command or one wait of its cause, so the bench compares each command, and the gap before it, against a list built from the configuration.

// File: rtl/dis_pkg.sv
// Shared constants for the DRAM initialization sequencer.
// Assumes an 8-bit opaque opcode space decoded by a downstream command engine.
package dis_pkg;

    localparam int OP_W = 8;

    // Memory type codes taken from the configuration field
    localparam int MT_DDR2 = 1;
    localparam int MT_DDR3 = 2;

    // Opcodes shared by both paths
    localparam logic [OP_W-1:0] OP_NOP      = 8'h01;
    localparam logic [OP_W-1:0] OP_PREALL   = 8'h02;
    localparam logic [OP_W-1:0] OP_EMR      = 8'h03;
    localparam logic [OP_W-1:0] OP_EMR2     = 8'h04;
    localparam logic [OP_W-1:0] OP_EMR3     = 8'h05;
    localparam logic [OP_W-1:0] OP_MR_USER  = 8'h06;
    localparam logic [OP_W-1:0] OP_MR_DLL   = 8'h07;
    localparam logic [OP_W-1:0] OP_REFRESH  = 8'h08;
    localparam logic [OP_W-1:0] OP_MR_CAL   = 8'h09;
    localparam logic [OP_W-1:0] OP_EMR_OCD  = 8'h0B;
    localparam logic [OP_W-1:0] OP_RST_CKE  = 8'h0C;
    // DDR3 mode register opcodes
    localparam logic [OP_W-1:0] OP_MRS1     = 8'h11;
    localparam logic [OP_W-1:0] OP_MRS2     = 8'h12;
    localparam logic [OP_W-1:0] OP_MRS3     = 8'h13;
    localparam logic [OP_W-1:0] OP_MRS0_USR = 8'h14;
    localparam logic [OP_W-1:0] OP_MRS0_DLL = 8'h15;

    // Fixed nanosecond and cycle waits
    localparam int NS_DDR2_SETTLE = 400;
    localparam int NS_REFRESH     = 200;
    localparam int CK_DDR3_CKE    = 250;
    localparam int CK_DDR2_TAIL   = 200;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STEP,
        S_WAIT,
        S_FIN,
        S_ERR
    } seq_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dis_ns_conv.sv
// Converts a step's nanosecond wait to clock cycles and adds its fixed cycle
// count: cycles = ns * mhz * ratio / 1000 + ck. Purely combinational.
// Assumes the product width is wide enough for the largest inputs (derived).
module dis_ns_conv #(
    parameter int NS_W    = 19,
    parameter int CLK_W   = 8,
    parameter int MHZ_W   = 12,
    parameter int RATIO_W = 3,
    parameter int CNT_W   = 35
) (
    input  logic [NS_W-1:0]    ns_i,
    input  logic [CLK_W-1:0]   ck_i,
    input  logic [MHZ_W-1:0]   mhz_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [CNT_W-1:0]   cyc_o
);
    localparam int PROD_W = NS_W + MHZ_W + RATIO_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;

    // Scale the wait by clock rate, then divide down from ns*MHz units
    always_comb begin
        prod  = PROD_W'(ns_i) * PROD_W'(mhz_i) * PROD_W'(ratio_i);
        quo   = prod / PROD_W'(1000);
        cyc_o = CNT_W'(quo) + CNT_W'(ck_i);
    end

endmodule

// File: rtl/dis_step_rom.sv
// Step table of the sequencer: for the current phase (preamble or per-rank),
// path and handoff mode it gives the opcode, its ns wait, its fixed cycle wait
// and whether this step ends the phase. Combinational.
module dis_step_rom
    import dis_pkg::*;
#(
    parameter int NS_W     = 19,
    parameter int CLK_W    = 8,
    parameter int RESET_NS = 500000
) (
    input  logic            pre_i,
    input  logic            ddr3_i,
    input  logic            handoff_i,
    input  logic [3:0]      idx_i,
    output logic [OP_W-1:0] op_o,
    output logic [NS_W-1:0] ns_o,
    output logic [CLK_W-1:0] ck_o,
    output logic            last_o
);
    // Select the step contents for the current position
    always_comb begin
        op_o   = OP_NOP;
        ns_o   = '0;
        ck_o   = '0;
        last_o = 1'b1;
        if (pre_i) begin
            if (ddr3_i) begin
                op_o = OP_RST_CKE;
                ns_o = NS_W'(RESET_NS);
                ck_o = CLK_W'(CK_DDR3_CKE);
            end else begin
                op_o = OP_NOP;
                ns_o = NS_W'(NS_DDR2_SETTLE);
            end
        end else if (ddr3_i) begin
            last_o = (idx_i == 4'd3);
            case (idx_i)
                4'd0:    op_o = OP_MRS2;
                4'd1:    op_o = OP_MRS3;
                4'd2:    op_o = OP_MRS1;
                default: op_o = handoff_i ? OP_MRS0_USR : OP_MRS0_DLL;
            endcase
        end else begin
            last_o = handoff_i ? (idx_i == 4'd4) : (idx_i == 4'd10);
            case (idx_i)
                4'd0: op_o = OP_PREALL;
                4'd1: op_o = OP_EMR2;
                4'd2: op_o = OP_EMR3;
                4'd3: op_o = OP_EMR;
                4'd4: op_o = handoff_i ? OP_MR_USER : OP_MR_DLL;
                4'd5: op_o = OP_PREALL;
                4'd6: begin
                    op_o = OP_REFRESH;
                    ns_o = NS_W'(NS_REFRESH);
                end
                4'd7: begin
                    op_o = OP_REFRESH;
                    ns_o = NS_W'(NS_REFRESH);
                end
                4'd8: op_o = OP_MR_CAL;
                4'd9: op_o = OP_EMR_OCD;
                default: begin
                    op_o = OP_EMR;
                    ck_o = CLK_W'(CK_DDR2_TAIL);
                end
            endcase
        end
    end

endmodule

// File: rtl/dis_delay_timer.sv
// Down-counter for the wait after an accepted command. Loaded with the wait
// length; last_o flags the final wait cycle. Assumes no load of zero.
module dis_delay_timer #(
    parameter int CNT_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt;

    // Load on command acceptance, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_i)
            cnt <= val_i;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last_o = (cnt == CNT_W'(1));

    // R2: an idle timer never wraps around
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load_i) |=> (cnt == '0));

endmodule

// File: rtl/dram_init_seq.sv
// DRAM initialization command sequencer. On start it captures the
// configuration, runs a path preamble (DDR2 NOP or DDR3 reset/CKE), then the
// per-rank mode-register sequence for each rank, holding every opcode until
// accepted and waiting the step's converted delay before the next one.
// Assumes cmd_ready may stall indefinitely; inputs other than start and
// cmd_ready are only sampled on an accepted start.
module dram_init_seq
    import dis_pkg::*;
#(
    parameter int MAX_RANKS = 4,
    parameter int MTYPE_W   = 3,
    parameter int MHZ_W     = 12,
    parameter int RATIO_W   = 3,
    parameter int RESET_NS  = 500000,
    localparam int NRANK_W  = $clog2(MAX_RANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 handoff,
    input  logic [MTYPE_W-1:0]   mem_type,
    input  logic [NRANK_W-1:0]   num_ranks,
    input  logic [MHZ_W-1:0]     clk_mhz,
    input  logic [RATIO_W-1:0]   rate_ratio,
    input  logic                 cmd_ready,
    output logic                 cmd_valid,
    output logic [OP_W-1:0]      cmd_op,
    output logic [MAX_RANKS-1:0] rank_sel,
    output logic                 odt_off,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    localparam int RANK_W = (MAX_RANKS > 1) ? $clog2(MAX_RANKS) : 1;
    localparam int NS_MAX = max_int(RESET_NS, max_int(NS_DDR2_SETTLE, NS_REFRESH));
    localparam int NS_W   = $clog2(NS_MAX + 1);
    localparam int CLK_W  = $clog2(max_int(CK_DDR3_CKE, CK_DDR2_TAIL) + 1);
    localparam int CNT_W  = NS_W + MHZ_W + RATIO_W + 1;

    seq_state_e         state;
    logic               cfg_ddr3;
    logic               cfg_ho;
    logic [NRANK_W-1:0] cfg_nr;
    logic [MHZ_W-1:0]   cfg_mhz;
    logic [RATIO_W-1:0] cfg_ratio;
    logic               in_pre;
    logic [3:0]         idx_q;
    logic [RANK_W-1:0]  rank_q;
    logic               fin_q;

    logic [OP_W-1:0]    st_op;
    logic [NS_W-1:0]    st_ns;
    logic [CLK_W-1:0]   st_ck;
    logic               st_last;
    logic [CNT_W-1:0]   st_delay;
    logic               tmr_last;
    logic               tmr_load;
    logic               accept;

    logic               nx_pre;
    logic [3:0]         nx_idx;
    logic [RANK_W-1:0]  nx_rank;
    logic               nx_fin;
    logic [NRANK_W-1:0] rank_nx;
    logic [NRANK_W-1:0] nr_clamp;
    logic [MAX_RANKS-1:0] rank_hot;

    dis_step_rom #(
        .NS_W     (NS_W),
        .CLK_W    (CLK_W),
        .RESET_NS (RESET_NS)
    ) u_rom (
        .pre_i     (in_pre),
        .ddr3_i    (cfg_ddr3),
        .handoff_i (cfg_ho),
        .idx_i     (idx_q),
        .op_o      (st_op),
        .ns_o      (st_ns),
        .ck_o      (st_ck),
        .last_o    (st_last)
    );

    dis_ns_conv #(
        .NS_W    (NS_W),
        .CLK_W   (CLK_W),
        .MHZ_W   (MHZ_W),
        .RATIO_W (RATIO_W),
        .CNT_W   (CNT_W)
    ) u_conv (
        .ns_i    (st_ns),
        .ck_i    (st_ck),
        .mhz_i   (cfg_mhz),
        .ratio_i (cfg_ratio),
        .cyc_o   (st_delay)
    );

    dis_delay_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (st_delay),
        .last_o (tmr_last)
    );

    // One-hot chip select for the rank being initialized
    for (genvar g = 0; g < MAX_RANKS; g++) begin : g_rank_hot
        assign rank_hot[g] = (rank_q == RANK_W'(g));
    end

    // Clamp the requested rank count to what the block can address
    assign nr_clamp = (num_ranks > NRANK_W'(MAX_RANKS)) ? NRANK_W'(MAX_RANKS) : num_ranks;

    assign accept   = (state == S_STEP) && cmd_ready;
    assign tmr_load = accept && (st_delay != '0);
    assign rank_nx  = NRANK_W'(rank_q) + NRANK_W'(1);

    // Position of the step after the current one, and whether it ends the run
    always_comb begin
        nx_pre  = in_pre;
        nx_idx  = idx_q + 4'd1;
        nx_rank = rank_q;
        nx_fin  = 1'b0;
        if (st_last) begin
            nx_idx = 4'd0;
            if (in_pre) begin
                nx_pre  = 1'b0;
                nx_rank = '0;
                nx_fin  = (cfg_nr == '0);
            end else if (rank_nx == cfg_nr) begin
                nx_fin = 1'b1;
            end else begin
                nx_rank = RANK_W'(rank_nx);
            end
        end
    end

    // Main control: capture, step through the table, wait, finish or halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cfg_ddr3  <= 1'b0;
            cfg_ho    <= 1'b0;
            cfg_nr    <= '0;
            cfg_mhz   <= '0;
            cfg_ratio <= '0;
            in_pre    <= 1'b1;
            idx_q     <= '0;
            rank_q    <= '0;
            fin_q     <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        cfg_ho    <= handoff;
                        cfg_nr    <= nr_clamp;
                        cfg_mhz   <= clk_mhz;
                        cfg_ratio <= rate_ratio;
                        in_pre    <= 1'b1;
                        idx_q     <= '0;
                        rank_q    <= '0;
                        fin_q     <= 1'b0;
                        if (mem_type == MTYPE_W'(MT_DDR2)) begin
                            cfg_ddr3 <= 1'b0;
                            state    <= S_STEP;
                        end else if (mem_type == MTYPE_W'(MT_DDR3)) begin
                            cfg_ddr3 <= 1'b1;
                            state    <= S_STEP;
                        end else begin
                            state    <= S_ERR;
                        end
                    end
                end
                S_STEP: begin
                    if (cmd_ready) begin
                        in_pre <= nx_pre;
                        idx_q  <= nx_idx;
                        rank_q <= nx_rank;
                        fin_q  <= nx_fin;
                        if (st_delay != '0)
                            state <= S_WAIT;
                        else
                            state <= nx_fin ? S_FIN : S_STEP;
                    end
                end
                S_WAIT: begin
                    if (tmr_last)
                        state <= fin_q ? S_FIN : S_STEP;
                end
                S_FIN:   state <= S_IDLE;
                S_ERR:   state <= S_ERR;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output decode from state and current step
    always_comb begin
        cmd_valid = (state == S_STEP);
        cmd_op    = cmd_valid ? st_op : '0;
        rank_sel  = !cmd_valid ? '0 : (in_pre ? '1 : rank_hot);
        odt_off   = cmd_valid && !in_pre && !cfg_ddr3;
        busy      = (state == S_STEP) || (state == S_WAIT);
        done      = (state == S_FIN);
        err       = (state == S_ERR);
    end

    // R10: a stalled command is held unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(rank_sel)));

    // R2: a zero wait gives back-to-back commands unless the run ends
    a_r2_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_delay == '0 && !nx_fin) |=> cmd_valid);

    // R2: a non-zero wait leaves the command bus idle in the next cycle
    a_r2_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_delay != '0) |=> !cmd_valid);

    // R9: per-rank commands stay inside the configured rank count
    a_r9_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !in_pre) |-> (NRANK_W'(rank_q) < cfg_nr));

    // R1: the error state is terminal until reset
    a_r1_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !cmd_valid && !busy));

    // R11: done is a single-cycle pulse with busy low
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

endmodule

// File: tb/dram_init_seq_test.sv
`timescale 1ns/1ps
module dram_init_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       handoff = 1'b0;
    logic [2:0] mem_type = '0;
    logic [2:0] num_ranks = '0;
    logic [11:0] clk_mhz = '0;
    logic [2:0] rate_ratio = '0;
    logic       cmd_ready = 1'b0;
    logic       cmd_valid;
    logic [7:0] cmd_op;
    logic [3:0] rank_sel;
    logic       odt_off;
    logic       busy;
    logic       done;
    logic       err;

    dram_init_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .handoff(handoff),
        .mem_type(mem_type), .num_ranks(num_ranks), .clk_mhz(clk_mhz),
        .rate_ratio(rate_ratio), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .rank_sel(rank_sel), .odt_off(odt_off),
        .busy(busy), .done(done), .err(err)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    int e_op [64];
    int e_rs [64];
    int e_odt[64];
    int e_gap[64];
    int n_exp;
    int pend;

    task automatic check(input string tag, input logic ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int conv(input int ns, input int mhz, input int ratio);
        return int'((longint'(ns) * mhz * ratio) / 1000);
    endfunction

    task automatic push(input int op, input int rs, input int odt, input int dly);
        e_op[n_exp]  = op;
        e_rs[n_exp]  = rs;
        e_odt[n_exp] = odt;
        e_gap[n_exp] = pend;
        pend = dly;
        n_exp++;
    endtask

    // Expected command list from the requirements
    task automatic build(input int ty, input int ho, input int nr, input int mhz, input int ratio);
        int nre;
        n_exp = 0;
        pend  = 0;
        nre = (nr > 4) ? 4 : nr;
        if (ty == 2) push(8'h0C, 4'hF, 0, conv(500000, mhz, ratio) + 250);
        else         push(8'h01, 4'hF, 0, conv(400, mhz, ratio));
        for (int r = 0; r < nre; r++) begin
            int rs = 1 << r;
            if (ty == 1) begin
                push(8'h02, rs, 1, 0);
                push(8'h04, rs, 1, 0);
                push(8'h05, rs, 1, 0);
                push(8'h03, rs, 1, 0);
                if (ho != 0) begin
                    push(8'h06, rs, 1, 0);
                end else begin
                    push(8'h07, rs, 1, 0);
                    push(8'h02, rs, 1, 0);
                    push(8'h08, rs, 1, conv(200, mhz, ratio));
                    push(8'h08, rs, 1, conv(200, mhz, ratio));
                    push(8'h09, rs, 1, 0);
                    push(8'h0B, rs, 1, 0);
                    push(8'h03, rs, 1, 200);
                end
            end else begin
                push(8'h12, rs, 0, 0);
                push(8'h13, rs, 0, 0);
                push(8'h11, rs, 0, 0);
                push((ho != 0) ? 8'h14 : 8'h15, rs, 0, 0);
            end
        end
    endtask

    task automatic run(input int ty, input int ho, input int nr, input int mhz, input int ratio, input int poke);
        int k = 0;
        int gap = 0;
        int cyc = 0;
        logic hold = 1'b0;
        logic busy_bad = 1'b0;
        logic [7:0] h_op = '0;
        logic [3:0] h_rs = '0;
        string tag;
        build(ty, ho, nr, mhz, ratio);
        @(negedge clk);
        mem_type = 3'(ty); handoff = ho[0]; num_ranks = 3'(nr);
        clk_mhz = 12'(mhz); rate_ratio = 3'(ratio); start = 1'b1;
        while (1) begin
            @(negedge clk);
            start = (poke != 0 && cyc == 2);
            cyc++;
            if (done) break;
            if (cyc > 60000) begin
                check("watchdog R11", 1'b0, cyc, 0);
                break;
            end
            if (!busy) busy_bad = 1'b1;
            if (cmd_valid) begin
                if (hold) begin
                    check("R10 hold", (cmd_op == h_op) && (rank_sel == h_rs), {cmd_op, rank_sel}, {h_op, h_rs});
                end else begin
                    if (k == 0) tag = (ty == 2) ? "R4 R2 first" : "R3 R2 first";
                    else if (ty == 1) tag = (ho != 0) ? "R5 R6 R9 R2 cmd" : "R5 R7 R9 R2 cmd";
                    else tag = "R8 R9 R2 cmd";
                    if (k < n_exp)
                        check(tag, (cmd_op == e_op[k][7:0]) && (rank_sel == e_rs[k][3:0]) &&
                              (odt_off == e_odt[k][0]) && (gap == e_gap[k]),
                              (longint'(cmd_op) << 28) | (longint'(rank_sel) << 24) | (longint'(odt_off) << 20) | gap,
                              (longint'(e_op[k]) << 28) | (longint'(e_rs[k]) << 24) | (longint'(e_odt[k]) << 20) | e_gap[k]);
                    else
                        check("R9 extra command", 1'b0, k, n_exp);
                end
                cmd_ready = ($urandom_range(0, 2) != 0);
                if (cmd_ready) begin
                    k++; gap = 0; hold = 1'b0;
                end else begin
                    hold = 1'b1; h_op = cmd_op; h_rs = rank_sel;
                end
            end else begin
                cmd_ready = $urandom_range(0, 1) != 0;
                gap++;
            end
        end
        start = 1'b0;
        check("R9 R11 end count and last wait", (k == n_exp) && (gap == pend) && !busy,
              (longint'(k) << 32) | gap, (longint'(n_exp) << 32) | pend);
        check("R11 busy throughout", !busy_bad, busy_bad, 0);
        @(negedge clk);
        check("R11 done single pulse", !done && !busy && !cmd_valid, {done, busy, cmd_valid}, 0);
        cmd_ready = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic run_bad(input int ty);
        logic bad = 1'b0;
        @(negedge clk);
        mem_type = 3'(ty); start = 1'b1; cmd_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 error entry", err && !busy && !cmd_valid, {err, busy, cmd_valid}, 3'b100);
        for (int i = 0; i < 20; i++) begin
            start = (i % 4 == 0);
            mem_type = 3'd1;
            @(negedge clk);
            if (!err || busy || cmd_valid || done) bad = 1'b1;
        end
        start = 1'b0; cmd_ready = 1'b0;
        check("R1 error terminal", !bad, bad, 0);
        do_reset();
        check("R12 reset clears error", !err && !busy && !done && !cmd_valid && rank_sel == 0 && !odt_off,
              {err, busy, done, cmd_valid, odt_off}, 0);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog R11 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset state", !cmd_valid && !busy && !done && !err && cmd_op == 0 && rank_sel == 0 && !odt_off,
              {cmd_valid, busy, done, err, odt_off}, 0);
        run(1, 0, 1, 10, 2, 0);
        run(1, 1, 2, 5, 1, 0);
        run(2, 0, 1, 1, 1, 0);
        run(2, 1, 0, 1, 1, 0);
        run(1, 0, 7, 3, 1, 1);
        run(1, 0, 4, 1, 1, 0);
        run(2, 0, 3, 2, 1, 1);
        run_bad(0);
        run_bad(3);
        run_bad(7);
        for (int i = 0; i < 8; i++) begin
            int ty = 1 + int'($urandom_range(0, 1));
            int ho = int'($urandom_range(0, 1));
            int nr = int'($urandom_range(0, 7));
            int mhz;
            int ratio;
            if (ty == 2) begin
                mhz = 1 + int'($urandom_range(0, 1));
                ratio = 1 + int'($urandom_range(0, 1));
            end else begin
                mhz = 1 + int'($urandom_range(0, 19));
                ratio = 1 + int'($urandom_range(0, 3));
            end
            run(ty, ho, nr, mhz, ratio, int'($urandom_range(0, 1)));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule